// File: doc/BRIEF.md
# Port Interrupt-on-Change Detector

This block watches a small general-purpose input port and raises a sticky change flag when an enabled pin no longer matches a reference snapshot. The snapshot is not the previous clock sample. It is the pin value captured at the most recent software access to the port, whether a read or a write. As long as any enabled pin disagrees with that snapshot, the flag is set again on every cycle. Software therefore has to touch the port before it can clear the flag.

The pins are asynchronous and pass through a synchronizer chain before they are compared or read. A simple register bus gives access to four registers, all on an 8-bit data bus:

| Address | Register | Contents |
|---|---|---|
| 0 | Port | Read returns the synchronized pins. A read or a write reloads the snapshot. |
| 1 | Pin-enable mask | One enable bit per pin. |
| 2 | Flag | Bit 0 is the change flag. Writing 1 to bit 0 clears it. |
| 3 | Control | Bit 0 is the change-interrupt enable. |

The block has two outputs driven from the flag:

- **Interrupt:** the flag gated by the change-interrupt enable and by a global interrupt enable input.
- **Wake request:** the flag gated only by the change-interrupt enable, so it can bring the device out of sleep while interrupts are globally masked.

Top module: `port_change_detect`

## Requirements
- R1: After reset the change flag, interrupt and wake outputs are 0. The pin-enable mask (address 1) and the control register (address 3) read as 0. The snapshot is 0. With the mask at 0, no pin activity sets the flag.
- R2: An enabled pin whose synchronized value differs from its snapshot bit sets the flag. A pin change applied to `pin_in` becomes visible on `chg_flag` three rising edges later: two synchronizer stages, then the flag register.
- R3: Pins whose mask bit is 0 never set the flag, whatever their value.
- R4: The flag is sticky. A clear strobe in a cycle where a set condition exists leaves the flag at 1. After a port access has removed the mismatch, a clear succeeds.
- R5: A bus write to address 0 also reloads the snapshot from the synchronized pins, which ends the mismatch.
- R6: The snapshot loads on the clock edge that ends a port access cycle. No set is taken in that cycle. A pin change that first reaches the synchronized value during a port read is absorbed into the snapshot and never raises the flag.
- R7: `chg_irq` equals flag AND control bit 0 AND `glb_int_en`. `wake_req` equals flag AND control bit 0, independent of `glb_int_en`.
- R8: A read of address 2 returns the flag in bit 0, with the upper bits 0. A write with bit 0 = 1 clears the flag. A write with bit 0 = 0 leaves it unchanged.
- R9: A read of address 0 returns the synchronized pins in the low bits, with the upper bits 0. The mask register and the control register read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous port pins |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational for the selected register |
| glb_int_en | input | 1 | Global interrupt enable |
| chg_flag | output | 1 | Sticky change flag |
| chg_irq | output | 1 | Change interrupt request |
| wake_req | output | 1 | Sleep wake request |

## Verification
The bench builds the block with its defaults: six pins, an 8-bit bus and a two-stage synchronizer.

With these values, the two pad bits of the data bus are present. This lets the bench confirm that they read back as zero. The fixed three-edge path from pin to flag makes the cycle timing exact. The bench can therefore place a port read in precisely the cycle where a new synchronized value first appears, which tests the absorbed-change case.

The scoreboard also covers the other corner cases: a clear that collides with a live mismatch, a snapshot reload caused by a port write, and the wake output with global interrupts masked.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

   // Register selector on the simple bus
   typedef enum logic [1:0] {
      PCD_PORT = 2'd0,
      PCD_MASK = 2'd1,
      PCD_FLAG = 2'd2,
      PCD_CTRL = 2'd3
   } pcd_reg_e;

   localparam int unsigned PCD_ADDR_W = 2;

endpackage

// File: rtl/pcd_sync.sv
// Multi-stage synchronizer for the asynchronous pins
module pcd_sync #(
   parameter int unsigned W      = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q_sync
);

   if (W < 1) begin : g_bad_w
      $error("pcd_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("pcd_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pcd_regs.sv
// Register decode: pin-enable mask, control bit, strobes and read mux
module pcd_regs
   import pcd_pkg::*;
#(
   parameter int unsigned NPINS = 6,
   parameter int unsigned DW    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PCD_ADDR_W-1:0] bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NPINS-1:0]      pins_sync,
   input  logic                  flag_q,
   output logic [NPINS-1:0]      pin_mask,
   output logic                  chg_ie,
   output logic                  port_acc,
   output logic                  clr_stb
);

   if (NPINS < 1 || NPINS > DW) begin : g_bad_npins
      $error("pcd_regs: NPINS must be between 1 and DW");
   end

   pcd_reg_e sel;
   logic     hit_port, hit_mask, hit_flag, hit_ctrl;
   logic     unused_wdata;

   assign sel      = pcd_reg_e'(bus_addr);
   assign hit_port = (sel == PCD_PORT);
   assign hit_mask = (sel == PCD_MASK);
   assign hit_flag = (sel == PCD_FLAG);
   assign hit_ctrl = (sel == PCD_CTRL);

   // Any read or write of the port counts as an access
   assign port_acc = hit_port && (bus_rd || bus_wr);
   assign clr_stb  = hit_flag && bus_wr && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_mask <= '0;
         chg_ie   <= 1'b0;
      end else if (bus_wr) begin
         if (hit_mask) pin_mask <= bus_wdata[NPINS-1:0];
         if (hit_ctrl) chg_ie   <= bus_wdata[0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         PCD_PORT: bus_rdata[NPINS-1:0] = pins_sync;
         PCD_MASK: bus_rdata[NPINS-1:0] = pin_mask;
         PCD_FLAG: bus_rdata[0]         = flag_q;
         PCD_CTRL: bus_rdata[0]         = chg_ie;
         default:  bus_rdata            = '0;
      endcase
   end

   assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/pcd_refcmp.sv
// Snapshot latch and per-pin mismatch compare
module pcd_refcmp #(
   parameter int unsigned NPINS = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins_sync,
   input  logic [NPINS-1:0] pin_mask,
   input  logic             port_acc,
   output logic             mismatch
);

   logic [NPINS-1:0] snap_q;
   logic [NPINS-1:0] diff;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_q <= '0;
      else if (port_acc) snap_q <= pins_sync;
   end

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign diff[i] = pin_mask[i] & (pins_sync[i] ^ snap_q[i]);
   end

   assign mismatch = |diff;

   // R5: the snapshot holds the pins seen during the access cycle
   assert_snap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      port_acc |=> (snap_q == $past(pins_sync)));

endmodule

// File: rtl/pcd_flag.sv
// Sticky change flag: set has priority over software clear
module pcd_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_stb,
   output logic flag_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_req) flag_q <= 1'b1;
      else if (clr_stb) flag_q <= 1'b0;
   end

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_req |=> flag_q);

   assert_clear_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_stb && !set_req) |=> !flag_q);

endmodule

// File: rtl/port_change_detect.sv
module port_change_detect
   import pcd_pkg::*;
#(
   parameter int unsigned NPINS       = 6,
   parameter int unsigned DW          = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NPINS-1:0]      pin_in,
   input  logic [PCD_ADDR_W-1:0] bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic                  glb_int_en,
   output logic                  chg_flag,
   output logic                  chg_irq,
   output logic                  wake_req
);

   if (NPINS < 1 || NPINS > DW) begin : g_bad_cfg
      $error("port_change_detect: NPINS must be between 1 and DW");
   end

   logic [NPINS-1:0] pins_sync;
   logic [NPINS-1:0] pin_mask;
   logic             chg_ie;
   logic             port_acc;
   logic             clr_stb;
   logic             mismatch;
   logic             set_req;

   pcd_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (pins_sync)
   );

   pcd_regs #(.NPINS(NPINS), .DW(DW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pins_sync (pins_sync),
      .flag_q    (chg_flag),
      .pin_mask  (pin_mask),
      .chg_ie    (chg_ie),
      .port_acc  (port_acc),
      .clr_stb   (clr_stb)
   );

   pcd_refcmp #(.NPINS(NPINS)) u_refcmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .pins_sync (pins_sync),
      .pin_mask  (pin_mask),
      .port_acc  (port_acc),
      .mismatch  (mismatch)
   );

   // A port access cycle absorbs any change into the snapshot
   assign set_req = mismatch && !port_acc;

   pcd_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (set_req),
      .clr_stb (clr_stb),
      .flag_q  (chg_flag)
   );

   assign wake_req = chg_flag & chg_ie;
   assign chg_irq  = wake_req & glb_int_en;

   // R6: the flag never rises straight after a port access cycle
   assert_no_rise_on_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chg_flag) |-> $past(!port_acc));

   // R3: with every pin masked off the flag cannot rise
   assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pin_mask) == '0) |-> !$rose(chg_flag));

endmodule

// File: tb/port_change_detect_tb.sv
`timescale 1ns/1ps
module port_change_detect_tb;

   localparam int NPINS = 6;
   localparam int DW    = 8;

   typedef struct {
      int         kind;   // 0 flag, 1 irq, 2 wake, 3 rdata
      logic [7:0] exp;
      string      req;
   } item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NPINS-1:0] pin_in = '0;
   logic [1:0]       bus_addr = '0;
   logic             bus_rd = 1'b0;
   logic             bus_wr = 1'b0;
   logic [DW-1:0]    bus_wdata = '0;
   logic [DW-1:0]    bus_rdata;
   logic             glb_int_en = 1'b0;
   logic             chg_flag, chg_irq, wake_req;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   item_t sb_q [$];

   always #2.5 clk = ~clk;

   port_change_detect #(.NPINS(NPINS), .DW(DW), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_addr(bus_addr),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .glb_int_en(glb_int_en), .chg_flag(chg_flag),
      .chg_irq(chg_irq), .wake_req(wake_req)
   );

   // Monitor: compare queued expectations at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it = sb_q.pop_front();
            case (it.kind)
               0:       got = {7'd0, chg_flag};
               1:       got = {7'd0, chg_irq};
               2:       got = {7'd0, wake_req};
               default: got = bus_rdata;
            endcase
            total++;
            if (got !== it.exp) begin
               bad++;
               $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic expect_out(input int kind, input logic [7:0] exp, input string req);
      item_t it;
      it.kind = kind;
      it.exp  = exp;
      it.req  = req;
      sb_q.push_back(it);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      step();
      bus_wr    = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string req);
      bus_addr = a;
      bus_rd   = 1'b1;
      expect_out(3, exp, req);
      step();
      bus_rd   = 1'b0;
   endtask

   initial begin
      #200000;
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      step();
      // R1: reset state
      expect_out(0, 8'h00, "R1 flag");
      expect_out(1, 8'h00, "R1 irq");
      expect_out(2, 8'h00, "R1 wake");
      step();
      bus_read(2'd1, 8'h00, "R1 mask");
      bus_read(2'd3, 8'h00, "R1 ctrl");
      pin_in = 6'h15;
      idle(4);
      expect_out(0, 8'h00, "R1 masked after reset");
      step();
      // R9: port read returns synchronized pins; loads snapshot
      bus_read(2'd0, 8'h15, "R9 port read");
      bus_write(2'd1, 8'h0F);
      bus_write(2'd3, 8'h01);
      bus_read(2'd1, 8'h0F, "R9 mask readback");
      bus_read(2'd3, 8'h01, "R9 ctrl readback");
      expect_out(0, 8'h00, "R2 no mismatch");
      step();
      // R3: masked pin 5 toggles
      pin_in = 6'h35;
      idle(4);
      expect_out(0, 8'h00, "R3 masked pin");
      step();
      // R2: enabled pin 1 toggles; three-edge latency
      pin_in = 6'h37;
      idle(2);
      expect_out(0, 8'h00, "R2 before third edge");
      step();
      expect_out(0, 8'h01, "R2 after third edge");
      expect_out(1, 8'h00, "R7 irq gated by glb");
      expect_out(2, 8'h01, "R7 wake without glb");
      step();
      glb_int_en = 1'b1;
      expect_out(1, 8'h01, "R7 irq with glb");
      step();
      glb_int_en = 1'b0;
      // R4: clear loses against a live mismatch
      bus_write(2'd2, 8'h01);
      expect_out(0, 8'h01, "R4 clear during mismatch");
      step();
      bus_read(2'd0, 8'h37, "R4 port read");
      expect_out(0, 8'h01, "R4 sticky after access");
      bus_write(2'd2, 8'h00);
      expect_out(0, 8'h01, "R8 write zero no clear");
      bus_read(2'd2, 8'h01, "R8 flag read");
      bus_write(2'd2, 8'h01);
      expect_out(0, 8'h00, "R4 clear after access");
      bus_read(2'd2, 8'h00, "R8 flag read cleared");
      // R5: port write reloads snapshot
      pin_in = 6'h36;
      idle(3);
      expect_out(0, 8'h01, "R5 set by pin0");
      step();
      bus_write(2'd0, 8'hAA);
      bus_write(2'd2, 8'h01);
      expect_out(0, 8'h00, "R5 cleared after write");
      idle(3);
      expect_out(0, 8'h00, "R5 stays clear");
      step();
      // R6: change reaches sync value in the read cycle
      pin_in = 6'h34;
      idle(2);
      bus_read(2'd0, 8'h34, "R6 read sees new value");
      idle(3);
      expect_out(0, 8'h00, "R6 change absorbed");
      step();
      // R7: control bit off blocks wake and irq
      pin_in = 6'h35;
      idle(3);
      glb_int_en = 1'b1;
      expect_out(0, 8'h01, "R7 flag set");
      expect_out(1, 8'h01, "R7 irq set");
      step();
      bus_write(2'd3, 8'h00);
      expect_out(2, 8'h00, "R7 wake off");
      expect_out(1, 8'h00, "R7 irq off");
      expect_out(0, 8'h01, "R7 flag remains");
      step();
      step();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule